// File: doc/BRIEF.md
# Dual Transmit Frame Buffer Controller

This block is the transmit half of a small Ethernet MAC. It holds two frame buffers, ping and pong, that a processor fills with 32-bit word writes. Each buffer has its own byte-length register and its own status register. Software hands a buffer to the hardware by setting the busy bit in its status register. The block then reads the buffer back and presents the frame one byte at a time on a valid/ready byte stream. When the last byte has been accepted, busy clears. Preamble, FCS and PHY timing are handled by later stages.

Setting the program bit together with busy starts a different action. The first six bytes of the buffer become the station MAC address, and nothing appears on the stream. If both buffers are waiting, the serializer alternates between them, so neither buffer can be skipped. When a buffer completes and both the global enable pin and that buffer's enable bit are set, the block emits a one-cycle interrupt pulse.

The stream follows valid/ready rules. A byte transfers on each clock edge where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, the byte and the last flag stay unchanged. The one exception is an abort: it withdraws `tx_valid` at once, in the middle of a frame.

Top module: `txbuf_dual`

## Requirements
- R1: After reset, both status registers read 0, `tx_valid` and `tx_irq` are low, and `station_mac` is 0.
- R2: Byte address bit 11 selects the buffer: 0 for ping, 1 for pong. Within a buffer, the offset 0x7F4 holds the length in bits [15:0], and reads return 0 in bits [31:16]. The offset 0x7FC holds the status, with busy in bit 0, program in bit 1 and interrupt enable in bit 3. Offsets below `4*BUF_WORDS` are frame words. Reads of frame words return 0.
- R3: A status write with bit 0 set, and bit 1 clear, to a buffer that is not busy sends exactly the length's worth of bytes. Byte k is taken from word k/4, byte lane k%4, lowest lane first. `tx_last` is high on the final byte only.
- R4: While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_last` hold their values.
- R5: Busy clears at the clock edge where the final byte is accepted.
- R6: A status write with bits 0 and 1 both set stores buffer bytes 0 to 5 into `station_mac`. Byte i goes to bits [8i+7:8i]. No byte is sent, the length register is ignored, and both bits then clear.
- R7: Writing the value 0 to a status register returns that buffer to idle. If the buffer is being sent, `tx_valid` falls on the next cycle, and no interrupt is raised.
- R8: A buffer that becomes pending while the other buffer is being sent goes out next. After a buffer completes, the other buffer has priority.
- R9: `tx_irq` is high for exactly one cycle, in the cycle after a completion, only when the buffer's interrupt enable bit and `irq_global_en` were both set at completion.
- R10: While a buffer is busy, writes to its frame words and to its length register are ignored. Status writes other than 0 change only the interrupt enable bit.
- R11: A length of 0 completes without sending any byte. A length above `4*BUF_WORDS` is reduced to `4*BUF_WORDS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Register/buffer write strobe |
| bus_wr_addr | input | 12 | Write byte address |
| bus_wr_data | input | 32 | Write data |
| bus_rd_en | input | 1 | Register read strobe |
| bus_rd_addr | input | 12 | Read byte address |
| bus_rd_data | output | 32 | Read data, one cycle after the strobe |
| irq_global_en | input | 1 | Global interrupt enable |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream sink ready |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the frame |
| station_mac | output | 48 | Station address loaded by a program command |
| tx_irq | output | 1 | Completion interrupt pulse |

## Verification
The bench builds the block with `BUF_WORDS=64` and `PONG_EN=1`. The small capacity of 256 bytes lets a single frame reach the length clamp, which a full-size buffer would make slow. With pong enabled, both buffers can be queued behind each other to exercise the alternation rule. A random sink ready, with stalls forced on demand, tests byte hold, aborts and writes made while a buffer is busy.

// File: rtl/txb_pkg.sv
package txb_pkg;
  localparam logic [10:0] OFS_LEN  = 11'h7F4;
  localparam logic [10:0] OFS_STAT = 11'h7FC;
  localparam int          ST_BUSY  = 0;
  localparam int          ST_PROG  = 1;
  localparam int          ST_IE    = 3;
  localparam int          MAC_BYTES = 6;
  localparam int          LEN_W    = 16;

  typedef enum logic [1:0] {
    SZ_IDLE,
    SZ_FETCH,
    SZ_EMIT
  } sz_state_e;
endpackage

// File: rtl/txb_frame_ram.sv
module txb_frame_ram #(
  parameter int WORDS = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/txb_arbiter.sv
module txb_arbiter #(
  parameter int NBUF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pend,
  input  logic       idle,
  input  logic       done_now,
  input  logic       done_buf,
  output logic       grant,
  output logic       grant_buf
);
  generate
    if (NBUF > 1) begin : g_two
      logic nxt;
      always_ff @(posedge clk) begin
        if (!rst_n)        nxt <= 1'b0;
        else if (done_now) nxt <= ~done_buf;
      end
      assign grant_buf = pend[nxt] ? nxt : ~nxt;
      assign grant     = idle && (pend != 2'b00);
    end else begin : g_one
      assign grant_buf = 1'b0;
      assign grant     = idle && pend[0];
    end
  endgenerate
endmodule

// File: rtl/txb_serializer.sv
module txb_serializer
  import txb_pkg::*;
#(
  parameter int BUF_WORDS = 256,
  parameter int WAW       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_buf,
  input  logic             start_prog,
  input  logic [LEN_W-1:0] start_len,
  input  logic             abort,
  output logic [WAW-1:0]   ram_addr,
  input  logic [31:0]      ram_q,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_data,
  output logic             tx_last,
  output logic             idle,
  output logic             act_buf,
  output logic             done_now,
  output logic             mac_commit,
  output logic [47:0]      mac_val
);
  localparam logic [LEN_W-1:0] CAP = LEN_W'(BUF_WORDS * 4);

  sz_state_e        st;
  logic [LEN_W-1:0] remain;
  logic [WAW-1:0]   widx;
  logic [1:0]       lane;
  logic             prog_q;
  logic [47:0]      mac_stage;
  logic [7:0]       byte_now;
  logic             step;
  logic [2:0]       mac_idx;
  logic [LEN_W-1:0] eff_len;

  always_comb begin
    byte_now   = ram_q[{lane, 3'b000} +: 8];
    eff_len    = start_prog ? LEN_W'(MAC_BYTES)
               : ((start_len > CAP) ? CAP : start_len);
    mac_idx    = 3'(LEN_W'(MAC_BYTES) - remain);
    step       = (st == SZ_EMIT) && (prog_q || tx_ready);
    tx_valid   = (st == SZ_EMIT) && !prog_q;
    tx_data    = byte_now;
    tx_last    = (remain == LEN_W'(1));
    idle       = (st == SZ_IDLE);
    ram_addr   = widx;
    done_now   = !abort && (((st == SZ_FETCH) && (remain == '0)) ||
                            (step && (remain == LEN_W'(1))));
    mac_commit = done_now && prog_q;
    mac_val    = {byte_now, mac_stage[39:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= SZ_IDLE;
      remain    <= '0;
      widx      <= '0;
      lane      <= '0;
      prog_q    <= 1'b0;
      act_buf   <= 1'b0;
      mac_stage <= '0;
    end else begin
      case (st)
        SZ_IDLE: begin
          if (start) begin
            act_buf <= start_buf;
            prog_q  <= start_prog;
            remain  <= eff_len;
            widx    <= '0;
            lane    <= '0;
            st      <= SZ_FETCH;
          end
        end
        SZ_FETCH: begin
          if (abort || remain == '0) st <= SZ_IDLE;
          else                       st <= SZ_EMIT;
        end
        SZ_EMIT: begin
          if (abort) begin
            st <= SZ_IDLE;
          end else if (step) begin
            if (prog_q) mac_stage[{mac_idx, 3'b000} +: 8] <= byte_now;
            remain <= remain - LEN_W'(1);
            if (remain == LEN_W'(1)) begin
              st <= SZ_IDLE;
            end else if (lane == 2'd3) begin
              lane <= '0;
              widx <= widx + WAW'(1);
              st   <= SZ_FETCH;
            end else begin
              lane <= lane + 2'd1;
            end
          end
        end
        default: st <= SZ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txbuf_dual.sv
module txbuf_dual
  import txb_pkg::*;
#(
  parameter int BUF_WORDS = 256,
  parameter int PONG_EN   = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr_en,
  input  logic [11:0] bus_wr_addr,
  input  logic [31:0] bus_wr_data,
  input  logic        bus_rd_en,
  input  logic [11:0] bus_rd_addr,
  output logic [31:0] bus_rd_data,
  input  logic        irq_global_en,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  output logic [47:0] station_mac,
  output logic        tx_irq
);
  localparam int NBUF = (PONG_EN != 0) ? 2 : 1;
  localparam int WAW  = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1;

  logic [1:0]       busy_v, prog_v, ie_v, pend_v, abort_v;
  logic [LEN_W-1:0] len_v  [2];
  logic [31:0]      ramq_v [2];
  logic [WAW-1:0]   sz_addr;
  logic             grant, grant_buf, sz_idle, act_buf, done_now;
  logic             mac_commit;
  logic [47:0]      mac_val;
  logic [10:0]      wr_ofs, rd_ofs;
  logic [8:0]       wr_widx;
  logic             wr_zero;

  assign wr_ofs  = bus_wr_addr[10:0];
  assign rd_ofs  = bus_rd_addr[10:0];
  assign wr_widx = bus_wr_addr[10:2];
  assign wr_zero = (bus_wr_data == 32'd0);

  genvar b;
  generate
    for (b = 0; b < 2; b++) begin : g_buf
      if (b < NBUF) begin : g_on
        logic             busy_q, prog_q, ie_q;
        logic [LEN_W-1:0] len_q;
        logic             hit, stat_wr, len_wr, ram_we;

        assign hit     = bus_wr_en && (bus_wr_addr[11] == 1'(b));
        assign stat_wr = hit && (wr_ofs == OFS_STAT);
        assign len_wr  = hit && (wr_ofs == OFS_LEN);
        assign ram_we  = hit && (int'(wr_widx) < BUF_WORDS) && !busy_q;

        always_ff @(posedge clk) begin
          if (!rst_n) begin
            busy_q <= 1'b0;
            prog_q <= 1'b0;
            ie_q   <= 1'b0;
            len_q  <= '0;
          end else begin
            if (stat_wr) begin
              if (wr_zero) begin
                busy_q <= 1'b0;
                prog_q <= 1'b0;
                ie_q   <= 1'b0;
              end else if (busy_q) begin
                ie_q <= bus_wr_data[ST_IE];
              end else begin
                busy_q <= bus_wr_data[ST_BUSY];
                prog_q <= bus_wr_data[ST_PROG];
                ie_q   <= bus_wr_data[ST_IE];
              end
            end
            if (done_now && act_buf == 1'(b)) begin
              busy_q <= 1'b0;
              prog_q <= 1'b0;
            end
            if (len_wr && !busy_q) len_q <= bus_wr_data[LEN_W-1:0];
          end
        end

        txb_frame_ram #(.WORDS(BUF_WORDS), .AW(WAW)) u_ram (
          .clk   (clk),
          .we    (ram_we),
          .waddr (wr_widx[WAW-1:0]),
          .wdata (bus_wr_data),
          .raddr (sz_addr),
          .rdata (ramq_v[b])
        );

        assign busy_v[b]  = busy_q;
        assign prog_v[b]  = prog_q;
        assign ie_v[b]    = ie_q;
        assign len_v[b]   = len_q;
        assign abort_v[b] = stat_wr && wr_zero;
        assign pend_v[b]  = busy_q && !(stat_wr && wr_zero);
      end else begin : g_off
        assign busy_v[b]  = 1'b0;
        assign prog_v[b]  = 1'b0;
        assign ie_v[b]    = 1'b0;
        assign len_v[b]   = '0;
        assign ramq_v[b]  = '0;
        assign abort_v[b] = 1'b0;
        assign pend_v[b]  = 1'b0;
      end
    end
  endgenerate

  txb_arbiter #(.NBUF(NBUF)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend      (pend_v),
    .idle      (sz_idle),
    .done_now  (done_now),
    .done_buf  (act_buf),
    .grant     (grant),
    .grant_buf (grant_buf)
  );

  txb_serializer #(.BUF_WORDS(BUF_WORDS), .WAW(WAW)) u_ser (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (grant),
    .start_buf  (grant_buf),
    .start_prog (prog_v[grant_buf]),
    .start_len  (len_v[grant_buf]),
    .abort      (abort_v[act_buf]),
    .ram_addr   (sz_addr),
    .ram_q      (ramq_v[act_buf]),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data),
    .tx_last    (tx_last),
    .idle       (sz_idle),
    .act_buf    (act_buf),
    .done_now   (done_now),
    .mac_commit (mac_commit),
    .mac_val    (mac_val)
  );

  logic [31:0] rd_mux;
  logic        rsel;
  assign rsel = bus_rd_addr[11];

  always_comb begin
    rd_mux = '0;
    if (int'(rsel) < NBUF) begin
      if (rd_ofs == OFS_LEN)
        rd_mux = {16'd0, len_v[rsel]};
      else if (rd_ofs == OFS_STAT)
        rd_mux = {28'd0, ie_v[rsel], 1'b0, prog_v[rsel], busy_v[rsel]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rd_data <= '0;
      station_mac <= '0;
      tx_irq      <= 1'b0;
    end else begin
      if (bus_rd_en)  bus_rd_data <= rd_mux;
      if (mac_commit) station_mac <= mac_val;
      tx_irq <= done_now && ie_v[act_buf] && irq_global_en;
    end
  end
endmodule

// File: rtl/txb_chk.sv
module txb_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_data,
  input logic        tx_last,
  input logic        tx_irq,
  input logic        irq_global_en,
  input logic [1:0]  busy_v,
  input logic [1:0]  prog_v,
  input logic        act_buf,
  input logic        bus_wr_en,
  input logic [11:0] bus_wr_addr,
  input logic [31:0] bus_wr_data
);
  AST_VALID_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> busy_v[act_buf]); // R3

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (!tx_valid || ($stable(tx_data) && $stable(tx_last)))); // R4

  AST_LAST_FREES_PING: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last && !act_buf) |=> !busy_v[0]); // R5

  AST_LAST_FREES_PONG: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last && act_buf) |=> !busy_v[1]); // R5

  AST_PROG_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !prog_v[act_buf]); // R6

  AST_ABORT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && bus_wr_en && bus_wr_addr == {act_buf, 11'h7FC} && bus_wr_data == 32'd0)
      |=> !tx_valid); // R7

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq); // R9

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> $past(irq_global_en)); // R9
endmodule

bind txbuf_dual txb_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tx_valid      (tx_valid),
  .tx_ready      (tx_ready),
  .tx_data       (tx_data),
  .tx_last       (tx_last),
  .tx_irq        (tx_irq),
  .irq_global_en (irq_global_en),
  .busy_v        (busy_v),
  .prog_v        (prog_v),
  .act_buf       (act_buf),
  .bus_wr_en     (bus_wr_en),
  .bus_wr_addr   (bus_wr_addr),
  .bus_wr_data   (bus_wr_data)
);

// File: tb/txbuf_dual_tb.sv
module txbuf_dual_tb;
  localparam int BW  = 64;
  localparam int CAP = BW * 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic [11:0] bus_wr_addr = '0;
  logic [31:0] bus_wr_data = '0;
  logic        bus_rd_en = 1'b0;
  logic [11:0] bus_rd_addr = '0;
  logic [31:0] bus_rd_data;
  logic        irq_global_en = 1'b1;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        tx_last;
  logic [47:0] station_mac;
  logic        tx_irq;

  always #10 clk = ~clk;

  txbuf_dual #(.BUF_WORDS(BW), .PONG_EN(1)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .bus_wr_en(bus_wr_en), .bus_wr_addr(bus_wr_addr), .bus_wr_data(bus_wr_data),
    .bus_rd_en(bus_rd_en), .bus_rd_addr(bus_rd_addr), .bus_rd_data(bus_rd_data),
    .irq_global_en(irq_global_en),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .station_mac(station_mac), .tx_irq(tx_irq)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [31:0] mdl [2][BW];
  logic [7:0]  cap_d [$];
  logic        cap_l [$];
  logic [7:0]  exp_d [$];
  logic        exp_l [$];
  int          irq_cnt = 0;
  bit          hold_rdy = 0;
  int          rdy_pct = 100;
  logic        stall_pend = 1'b0;
  logic [7:0]  stall_d;
  logic        stall_l;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // stream monitor and sink, away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_irq) irq_cnt++;
      if (stall_pend && tx_valid) check("R4 stalled byte held", {tx_last, tx_data}, {stall_l, stall_d});
      tx_ready = hold_rdy ? 1'b0 : (($urandom % 100) < rdy_pct);
      if (tx_valid && tx_ready) begin
        cap_d.push_back(tx_data);
        cap_l.push_back(tx_last);
      end
      stall_pend = tx_valid && !tx_ready;
      stall_d = tx_data;
      stall_l = tx_last;
    end
  end

  function automatic logic [11:0] adr(input int b, input int ofs);
    return {1'(b), 11'(ofs)};
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_wr_en = 1'b1; bus_wr_addr = a; bus_wr_data = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_rd_en = 1'b1; bus_rd_addr = a;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rd_data;
  endtask

  task automatic load(input int b, input int nbytes);
    int nw = (nbytes + 3) / 4;
    if (nw > BW) nw = BW;
    for (int w = 0; w < nw; w++) begin
      logic [31:0] d = $urandom;
      mdl[b][w] = d;
      wr(adr(b, w * 4), d);
    end
  endtask

  task automatic expect_frame(input int b, input int len);
    int n = (len > CAP) ? CAP : len;
    for (int k = 0; k < n; k++) begin
      exp_d.push_back(mdl[b][k / 4][8 * (k % 4) +: 8]);
      exp_l.push_back(k == n - 1);
    end
  endtask

  task automatic wait_free(input int b);
    logic [31:0] s;
    for (int i = 0; i < 4000; i++) begin
      rd(adr(b, 12'h7FC), s);
      if (!s[0]) break;
    end
  endtask

  task automatic compare_stream(input string tag);
    check({tag, " byte count"}, 64'(cap_d.size()), 64'(exp_d.size()));
    if (cap_d.size() == exp_d.size()) begin
      for (int k = 0; k < exp_d.size(); k++) begin
        if (cap_d[k] !== exp_d[k] || cap_l[k] !== exp_l[k])
          check({tag, " byte/last"}, {55'd0, cap_l[k], cap_d[k]}, {55'd0, exp_l[k], exp_d[k]});
      end
      n_cmp++;
    end
    cap_d.delete(); cap_l.delete(); exp_d.delete(); exp_l.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    int i0;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(adr(0, 12'h7FC), s); check("R1 ping status", s, 0);
    rd(adr(1, 12'h7FC), s); check("R1 pong status", s, 0);
    check("R1 outputs", {tx_valid, tx_irq, station_mac}, 0);

    // R2 register map
    wr(adr(1, 12'h7F4), 32'hFFFF_ABCD);
    rd(adr(1, 12'h7F4), s); check("R2 pong length read", s, 32'h0000_ABCD);
    wr(adr(1, 12'h7FC), 32'h8);
    rd(adr(1, 12'h7FC), s); check("R2 pong ie bit3", s, 32'h8);
    wr(adr(1, 12'h7FC), 32'h0);
    rd(adr(0, 12'h000), s); check("R2 frame word reads zero", s, 0);

    // R3 R5 R9 directed frame
    load(0, 13); wr(adr(0, 12'h7F4), 13);
    i0 = irq_cnt;
    wr(adr(0, 12'h7FC), 32'h9);
    expect_frame(0, 13);
    wait_free(0);
    compare_stream("R3 directed 13 bytes");
    rd(adr(0, 12'h7FC), s); check("R5 busy cleared", s & 1, 0);
    check("R9 irq with enables", irq_cnt - i0, 1);

    // R3 R9 random frames with random back-pressure
    for (int it = 0; it < 24; it++) begin
      int b = $urandom % 2;
      int len = 1 + $urandom % 40;
      int ie = $urandom % 2;
      irq_global_en = 1'($urandom % 2);
      rdy_pct = 30 + $urandom % 71;
      load(b, len); wr(adr(b, 12'h7F4), len);
      i0 = irq_cnt;
      wr(adr(b, 12'h7FC), (ie << 3) | 1);
      expect_frame(b, len);
      wait_free(b);
      compare_stream("R3 random frame");
      check("R9 irq gating", irq_cnt - i0, (ie && irq_global_en) ? 1 : 0);
    end
    irq_global_en = 1'b1;
    rdy_pct = 70;

    // R8 ordering: pong queued behind ping, then ping behind pong
    hold_rdy = 1;
    load(0, 9); wr(adr(0, 12'h7F4), 9);
    load(1, 6); wr(adr(1, 12'h7F4), 6);
    wr(adr(0, 12'h7FC), 1);
    wr(adr(1, 12'h7FC), 1);
    expect_frame(0, 9); expect_frame(1, 6);
    hold_rdy = 0;
    wait_free(0); wait_free(1);
    compare_stream("R8 ping then pong");
    hold_rdy = 1;
    load(1, 5); wr(adr(1, 12'h7F4), 5);
    load(0, 7); wr(adr(0, 12'h7F4), 7);
    wr(adr(1, 12'h7FC), 1);
    wr(adr(0, 12'h7FC), 1);
    expect_frame(1, 5); expect_frame(0, 7);
    hold_rdy = 0;
    wait_free(0); wait_free(1);
    compare_stream("R8 pong then ping");

    // R10 writes to a busy buffer are ignored
    hold_rdy = 1;
    load(0, 8); wr(adr(0, 12'h7F4), 8);
    wr(adr(0, 12'h7FC), 1);
    wr(adr(0, 12'h000), 32'hDEAD_BEEF);
    wr(adr(0, 12'h7F4), 3);
    wr(adr(0, 12'h7FC), 32'h3);
    rd(adr(0, 12'h7F4), s); check("R10 length kept", s, 8);
    rd(adr(0, 12'h7FC), s); check("R10 status only ie", s, 32'h1);
    expect_frame(0, 8);
    hold_rdy = 0;
    wait_free(0);
    compare_stream("R10 frame unchanged");

    // R7 abort mid-frame
    hold_rdy = 1;
    load(0, 20); wr(adr(0, 12'h7F4), 20);
    i0 = irq_cnt;
    wr(adr(0, 12'h7FC), 32'h9);
    repeat (3) @(negedge clk);
    wr(adr(0, 12'h7FC), 0);
    check("R7 valid dropped", tx_valid, 0);
    rd(adr(0, 12'h7FC), s); check("R7 status idle", s, 0);
    hold_rdy = 0;
    repeat (5) @(negedge clk);
    check("R7 no bytes", cap_d.size(), 0);
    check("R7 no irq", irq_cnt - i0, 0);
    load(0, 4); wr(adr(0, 12'h7F4), 4); wr(adr(0, 12'h7FC), 1);
    expect_frame(0, 4);
    wait_free(0);
    compare_stream("R7 frame after abort");

    // R6 station address load
    wr(adr(1, 12'h000), 32'h4433_2211); wr(adr(1, 12'h004), 32'hAAAA_6655);
    wr(adr(1, 12'h7F4), 50);
    i0 = irq_cnt;
    wr(adr(1, 12'h7FC), 32'hB);
    wait_free(1);
    repeat (2) @(negedge clk);
    check("R6 station mac", station_mac, 48'h6655_4433_2211);
    check("R6 nothing sent", cap_d.size(), 0);
    rd(adr(1, 12'h7FC), s); check("R6 bits cleared", s, 32'h8);
    check("R9 irq after program", irq_cnt - i0, 1);

    // R11 zero length and clamp
    wr(adr(0, 12'h7F4), 0);
    wr(adr(0, 12'h7FC), 1);
    wait_free(0);
    repeat (3) @(negedge clk);
    check("R11 zero length sends nothing", cap_d.size(), 0);
    load(0, CAP); wr(adr(0, 12'h7F4), 300);
    wr(adr(0, 12'h7FC), 1);
    expect_frame(0, 300);
    wait_free(0);
    compare_stream("R11 clamp to capacity");

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule